// File: doc/BRIEF.md
# Aging Counter Replacement Unit

This unit tracks how recently each of a small set of resident pages has been used and names the page that is the best candidate to evict. It approximates least-recently-used ordering. Every page has a use flag and an age register. A one-cycle access strobe for a page sets that page's use flag. At each periodic tick pulse, each age register moves one place toward its least significant bit, and the page's use flag fills the vacated top bit. All use flags then start the new interval at zero.

A reference in the latest interval therefore outweighs any number of older references. A page that has not been touched for a full register width of ticks reads zero. The victim output is combinational from the age registers. It names the page with the smallest age value, and the lowest-numbered page wins a tie. Surrounding logic uses it directly on a page fault.

Top module: `aging_unit`

## Requirements
- R1: A synchronous reset, active high, clears every age register to zero and clears every use flag.
- R2: A high `access_i[i]` in a cycle without a tick sets use flag i. The flag stays set until the next tick, however many further strobes arrive.
- R3: On a clock edge with `tick_i` high, page i's age register becomes its use flag followed by the upper AGE_W-1 bits of its old value. The flag goes in bit AGE_W-1 and bit 0 is dropped.
- R4: On an edge without `tick_i`, no age register changes.
- R5: A tick clears all use flags on the same edge. A strobe that arrives in the tick cycle sets its flag for the following interval only.
- R6: `victim_o` is the index of a page whose age value is the smallest of all pages. It follows the age registers without extra latency.
- R7: When several pages share the smallest age value, `victim_o` gives the lowest index among them.
- R8: From reset, take five intervals whose access sets are {0,2,4,5}, {0,1,4}, {0,1,3,5}, {0,4} and {1,2}, each followed by a tick. The ages then read 0x78, 0xB0, 0x88, 0x20, 0x58, 0x28 for pages 0 to 5, and `victim_o` reads 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| access_i | input | NUM_PAGES | Per-page access strobe, bit i for page i |
| tick_i | input | 1 | Periodic aging pulse, one cycle |
| age_o | output | NUM_PAGES*AGE_W | Age registers, page i in bits [i*AGE_W +: AGE_W] |
| victim_o | output | $clog2(NUM_PAGES) | Index of the page with the smallest age |

## Verification
The bench targets a strobe that lands in the same cycle as a tick. A design that dropped it would under-age the page. A design that folded it into the current shift would set the wrong bit a tick early.

Ties on the smallest age are provoked on purpose: all pages at zero, all pages equal, and five pages equal behind one higher page. A scan with a non-strict compare would then report the highest index instead of the lowest.

The five-interval worked sequence catches a shift in the wrong direction or a use flag inserted at the wrong end, since either would give different final ages and a different victim. Long random runs against a behavioural model catch flags that clear early or counters that move without a tick.

// File: rtl/aging_pkg.sv
package aging_pkg;
    localparam int unsigned DEF_PAGES = 6;
    localparam int unsigned DEF_AGE_W = 8;
endpackage

// File: rtl/aging_refbits.sv
module aging_refbits #(
    parameter int unsigned NUM_PAGES = aging_pkg::DEF_PAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PAGES-1:0] access_i,
    input  logic                 tick_i,
    output logic [NUM_PAGES-1:0] used_o
);
    typedef struct packed {
        logic [NUM_PAGES-1:0] used;
    } ref_state_t;

    ref_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            // new interval starts; same-cycle strobes belong to it
            st_d.used = access_i;
        end else begin
            st_d.used = st_q.used | access_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign used_o = st_q.used;

    // R2: a set flag survives any non-tick edge
    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_chk
            p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
                (!tick_i && st_q.used[g]) |=> st_q.used[g])
                else $error("R2 flag %0d lost", g);
        end
    endgenerate

    // R5: after a tick the flags equal exactly that cycle's strobes
    p_clear_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (st_q.used == $past(access_i)))
        else $error("R5 flag clear wrong");
endmodule

// File: rtl/aging_counters.sv
module aging_counters #(
    parameter int unsigned NUM_PAGES = aging_pkg::DEF_PAGES,
    parameter int unsigned AGE_W     = aging_pkg::DEF_AGE_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick_i,
    input  logic [NUM_PAGES-1:0]            used_i,
    output logic [NUM_PAGES-1:0][AGE_W-1:0] age_o
);
    typedef struct packed {
        logic [NUM_PAGES-1:0][AGE_W-1:0] age;
    } age_state_t;

    age_state_t st_d, st_q;
    logic [NUM_PAGES-1:0][AGE_W-1:0] shifted;

    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_shift
            assign shifted[g] = {used_i[g], st_q.age[g][AGE_W-1:1]};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.age = shifted;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign age_o = st_q.age;

    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_chk
            // R3: top bit takes the flag, the rest is the old value moved down
            p_shift_r3: assert property (@(posedge clk) disable iff (rst)
                tick_i |=> (st_q.age[g] == {$past(used_i[g]), $past(st_q.age[g][AGE_W-1:1])}))
                else $error("R3 shift page %0d", g);
            // R4: no tick, no change
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                !tick_i |=> $stable(st_q.age[g]))
                else $error("R4 age %0d moved", g);
        end
    endgenerate
endmodule

// File: rtl/aging_victim.sv
module aging_victim #(
    parameter int unsigned NUM_PAGES = aging_pkg::DEF_PAGES,
    parameter int unsigned AGE_W     = aging_pkg::DEF_AGE_W,
    localparam int unsigned IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic [NUM_PAGES-1:0][AGE_W-1:0] age_i,
    output logic [IDX_W-1:0]                victim_o
);
    logic [AGE_W-1:0] best_val;

    always_comb begin
        best_val = age_i[0];
        victim_o = '0;
        // strict compare keeps the earliest index on ties
        for (int i = 1; i < NUM_PAGES; i++) begin
            if (age_i[i] < best_val) begin
                best_val = age_i[i];
                victim_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/aging_unit.sv
module aging_unit #(
    parameter int unsigned NUM_PAGES = aging_pkg::DEF_PAGES,
    parameter int unsigned AGE_W     = aging_pkg::DEF_AGE_W,
    localparam int unsigned IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PAGES-1:0]         access_i,
    input  logic                         tick_i,
    output logic [NUM_PAGES*AGE_W-1:0]   age_o,
    output logic [IDX_W-1:0]             victim_o
);
    logic [NUM_PAGES-1:0]            used_w;
    logic [NUM_PAGES-1:0][AGE_W-1:0] age_w;

    aging_refbits #(.NUM_PAGES(NUM_PAGES)) u_ref (
        .clk      (clk),
        .rst      (rst),
        .access_i (access_i),
        .tick_i   (tick_i),
        .used_o   (used_w)
    );

    aging_counters #(.NUM_PAGES(NUM_PAGES), .AGE_W(AGE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .used_i (used_w),
        .age_o  (age_w)
    );

    aging_victim #(.NUM_PAGES(NUM_PAGES), .AGE_W(AGE_W)) u_vic (
        .age_i    (age_w),
        .victim_o (victim_o)
    );

    assign age_o = age_w;

    // R1: reset leaves everything clear
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (age_w == '0 && used_w == '0))
        else $error("R1 reset state");

    generate
        for (genvar g = 0; g < NUM_PAGES; g++) begin : g_chk
            // R6: chosen page is no larger than any page
            p_victim_min_r6: assert property (@(posedge clk) disable iff (rst)
                age_w[victim_o] <= age_w[g])
                else $error("R6 victim not minimal vs %0d", g);
            // R7: every lower index is strictly larger
            p_tie_low_r7: assert property (@(posedge clk) disable iff (rst)
                (IDX_W'(g) < victim_o) |-> (age_w[g] > age_w[victim_o]))
                else $error("R7 tie not lowest at %0d", g);
        end
    endgenerate
endmodule

// File: tb/aging_unit_tb_top.sv
module aging_unit_tb_top;
    localparam int NP = 6;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] access_i = '0;
    logic          tick_i = 1'b0;
    logic [NP*AW-1:0] age_o;
    logic [2:0]    victim_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int age_m [NP];
    bit use_m [NP];
    bit last_tick = 0;

    always #5 clk = ~clk;

    aging_unit #(.NUM_PAGES(NP), .AGE_W(AW)) dut_i (
        .clk(clk), .rst(rst), .access_i(access_i), .tick_i(tick_i),
        .age_o(age_o), .victim_o(victim_o)
    );

    // behavioural reference
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NP; i++) begin age_m[i] = 0; use_m[i] = 0; end
            last_tick = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (tick_i) begin
                    age_m[i] = (age_m[i] >> 1) | (int'(use_m[i]) << (AW-1));
                    use_m[i] = access_i[i];
                end else begin
                    use_m[i] = use_m[i] | access_i[i];
                end
            end
            last_tick = tick_i;
        end
    end

    function automatic int model_victim();
        int best = 0;
        for (int i = 1; i < NP; i++) if (age_m[i] < age_m[best]) best = i;
        return best;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int i = 0; i < NP; i++)
                check(last_tick ? "R3 age" : "R4 age", int'(age_o[i*AW +: AW]), age_m[i]);
            check("R6/R7 victim", int'(victim_o), model_victim());
        end
    end

    task automatic step(input logic [NP-1:0] s, input logic t);
        access_i = s;
        tick_i   = t;
        @(negedge clk);
    endtask

    task automatic do_reset();
        access_i = '0; tick_i = 0; rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    function automatic int age_of(input int p);
        return int'(age_o[p*AW +: AW]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        for (int i = 0; i < NP; i++) check("R1 reset age", age_of(i), 0);
        // R7 all zero tie
        check("R7 all-zero tie", int'(victim_o), 0);

        // R8 worked sequence
        step(6'b110101, 0); step(6'b000000, 1);
        step(6'b010011, 0); step(6'b000000, 1);
        step(6'b101011, 0); step(6'b000000, 1);
        step(6'b010001, 0); step(6'b000000, 1);
        step(6'b000110, 0); step(6'b000000, 1);
        step(6'b000000, 0);
        check("R8 page0", age_of(0), 8'h78);
        check("R8 page1", age_of(1), 8'hB0);
        check("R8 page2", age_of(2), 8'h88);
        check("R8 page3", age_of(3), 8'h20);
        check("R8 page4", age_of(4), 8'h58);
        check("R8 page5", age_of(5), 8'h28);
        check("R8 R6 victim", int'(victim_o), 3);

        // R7 ties after equal use
        do_reset();
        step(6'b111111, 0); step(6'b000000, 1); step(6'b000000, 0);
        check("R7 all-equal victim", int'(victim_o), 0);
        step(6'b000001, 0); step(6'b000000, 1); step(6'b000000, 0);
        check("R7 five-way tie page0", age_of(0), 8'hC0);
        check("R7 five-way tie victim", int'(victim_o), 1);

        // R2 repeated strobes, R5 strobe on tick counts later
        do_reset();
        step(6'b000010, 0); step(6'b000010, 0); step(6'b000010, 0);
        step(6'b000100, 1); step(6'b000000, 0);
        check("R2 sticky flag page1", age_of(1), 8'h80);
        check("R5 tick-cycle strobe not in this shift", age_of(2), 8'h00);
        step(6'b000000, 1); step(6'b000000, 0);
        check("R5 tick-cycle strobe in next shift", age_of(2), 8'h80);
        check("R5 flags cleared page1", age_of(1), 8'h40);

        // random traffic against the model
        for (int c = 0; c < 3000; c++)
            step(NP'($urandom) & NP'($urandom), ($urandom % 4) == 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule